// File: doc/BRIEF.md
# Router Header and Parity Register Unit

This unit is the byte-wide datapath register block of a one-input, three-output packet router. The router's control FSM drives it with one-hot state indications, the incoming packet-valid signal and the FIFO-full status. It latches the header byte while the address is being decoded. It then sends that header and the following payload bytes on to the FIFO write port. When the target FIFO is full, it keeps the payload byte that arrived during the stall and sends it once the stall clears.

Alongside the data path, the unit keeps an XOR parity of the header and all payload bytes of the current packet. It captures the parity byte that trails the packet and reports a mismatch on an error flag. The FSM gets two further status signals back: one that says the trailing parity byte has been taken, and a one-cycle pulse that tells the FSM that packet valid dropped during the replay cycle after a stall.

Top module: `rtr_hdr_parity_unit`

## Requirements
- R1: While `rstN` is low at a rising clock edge, the header, hold, computed-parity and received-parity registers, `dataOut`, `parityDone`, `lowPktValid` and `parityErr` all become zero. A load-first cycle right after reset therefore drives `dataOut` to 0.
- R2: A cycle with `fsmDecode` and `pktValid` high stores `dataIn` as the header. A later `fsmLoadFirst` cycle places that header on `dataOut` after the next edge.
- R3: A `fsmLoadData` cycle with `fifoFull` low places `dataIn` on `dataOut` after the edge. This applies to payload bytes and to the trailing parity byte.
- R4: A `fsmLoadData` cycle with `fifoFull` high stores `dataIn` in the hold register and leaves `dataOut` unchanged. A later `fsmLoadAfterFull` cycle places the held byte on `dataOut`.
- R5: The computed parity restarts at each packet. It is set to the header on the load-first cycle and XORed with `dataIn` on every `fsmLoadData` cycle that has `pktValid` high.
- R6: The first `fsmLoadData` cycle with `pktValid` low stores `dataIn` as the received parity, and `parityDone` reads 1 after that edge.
- R7: `parityDone` stays high until a cycle with `fsmDecode` high, after which it reads 0.
- R8: One edge after `parityDone` rises, `parityErr` becomes 1 if the computed parity differs from the received parity, and 0 otherwise. It holds that value until the next packet start (`fsmDecode` with `pktValid` high), which clears it.
- R9: A `fsmLoadAfterFull` cycle with `pktValid` low makes `lowPktValid` read 1 for exactly the following cycle.
- R10: A `fsmLoadAfterFull` cycle with `pktValid` high leaves `lowPktValid` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| dataIn | input | 8 | Incoming byte from the router input |
| pktValid | input | 1 | Packet valid from the source |
| fsmDecode | input | 1 | FSM is in its address-decode state |
| fsmLoadFirst | input | 1 | FSM is loading the header byte |
| fsmLoadData | input | 1 | FSM is loading a payload or parity byte |
| fsmLoadAfterFull | input | 1 | FSM is replaying the byte held during a full stall |
| fifoFull | input | 1 | Target FIFO is full |
| dataOut | output | 8 | Byte presented to the FIFO write port |
| parityDone | output | 1 | Trailing parity byte has been captured |
| lowPktValid | output | 1 | Pulse: packet valid fell during the replay cycle |
| parityErr | output | 1 | Computed and received parity differ |

## Verification
The assertions assume a well-behaved FSM: at most one of the four state inputs is high in any cycle, and each packet follows the order decode, load-first, payload loads with optional stall-and-replay, then parity. The bench drives only such legal sequences. Within those sequences it draws the header, payload length, payload bytes, stall positions and the corrupted-parity choice from a seeded random source. It adds directed packets with no payload, a stall on the final byte, and a reset in the middle of a run, so that every state transition of the unit is reached under those assumptions.

// File: rtl/rhp_pkg.sv
package rhp_pkg;

  typedef struct packed {
    logic startPkt;    // decode with valid: new packet begins
    logic seedParity;  // load first: header goes out, parity seeded
    logic passByte;    // forward dataIn to FIFO
    logic holdByte;    // park dataIn during full stall
    logic replayHold;  // send parked byte
    logic accumParity; // fold payload byte into parity
    logic capParity;   // take trailing parity byte
    logic chkErr;      // compare parities
  } rhpStrobe_t;

endpackage

// File: rtl/rhp_ctrl.sv
module rhp_ctrl
  import rhp_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       pktValid,
  input  logic       fsmDecode,
  input  logic       fsmLoadFirst,
  input  logic       fsmLoadData,
  input  logic       fsmLoadAfterFull,
  input  logic       fifoFull,
  output rhpStrobe_t strb,
  output logic       parityDone,
  output logic       lowPktValid
);

  logic errArm;

  always_comb begin
    strb.startPkt    = fsmDecode && pktValid;
    strb.seedParity  = fsmLoadFirst;
    strb.passByte    = fsmLoadData && !fifoFull;
    strb.holdByte    = fsmLoadData && fifoFull;
    strb.replayHold  = fsmLoadAfterFull;
    strb.accumParity = fsmLoadData && pktValid;
    strb.capParity   = fsmLoadData && !pktValid && !parityDone;
    strb.chkErr      = errArm;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      parityDone  <= 1'b0;
      lowPktValid <= 1'b0;
      errArm      <= 1'b0;
    end else begin
      if (fsmDecode)           parityDone <= 1'b0;
      else if (strb.capParity) parityDone <= 1'b1;
      lowPktValid <= fsmLoadAfterFull && !pktValid;
      errArm      <= strb.capParity;
    end
  end

  // Input assumption: the FSM presents at most one state at a time (R2..R4)
  p_fsm_onehot_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({fsmDecode, fsmLoadFirst, fsmLoadData, fsmLoadAfterFull}));

  p_done_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    fsmDecode |=> !parityDone);

  p_low_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    lowPktValid |-> $past(fsmLoadAfterFull && !pktValid));

  p_low_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    (fsmLoadAfterFull && pktValid) |=> !lowPktValid);

endmodule

// File: rtl/rhp_datapath.sv
module rhp_datapath
  import rhp_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  rhpStrobe_t        strb,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut,
  output logic              parityErr
);

  localparam logic [DATA_W-1:0] ZERO = '0;

  logic [DATA_W-1:0] headerReg;
  logic [DATA_W-1:0] holdReg;
  logic [DATA_W-1:0] calcParity;
  logic [DATA_W-1:0] rxParity;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      headerReg <= ZERO;
      holdReg   <= ZERO;
    end else begin
      if (strb.startPkt) headerReg <= dataIn;
      if (strb.holdByte) holdReg   <= dataIn;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                 dataOut <= ZERO;
    else if (strb.seedParity)  dataOut <= headerReg;
    else if (strb.replayHold)  dataOut <= holdReg;
    else if (strb.passByte)    dataOut <= dataIn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      calcParity <= ZERO;
      rxParity   <= ZERO;
    end else begin
      if (strb.startPkt)         calcParity <= ZERO;
      else if (strb.seedParity)  calcParity <= headerReg;
      else if (strb.accumParity) calcParity <= calcParity ^ dataIn;
      if (strb.startPkt)         rxParity <= ZERO;
      else if (strb.capParity)   rxParity <= dataIn;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)              parityErr <= 1'b0;
    else if (strb.startPkt) parityErr <= 1'b0;
    else if (strb.chkErr)   parityErr <= (calcParity != rxParity);
  end

  p_hdr_capture_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.startPkt |=> headerReg == $past(dataIn));

  p_hold_keep_r4: assert property (@(posedge clk) disable iff (!rstN)
    strb.holdByte |=> $stable(dataOut));

  p_replay_r4: assert property (@(posedge clk) disable iff (!rstN)
    strb.replayHold |=> dataOut == $past(holdReg));

  p_seed_r5: assert property (@(posedge clk) disable iff (!rstN)
    strb.seedParity |=> calcParity == $past(headerReg));

endmodule

// File: rtl/rtr_hdr_parity_unit.sv
module rtr_hdr_parity_unit
  import rhp_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              pktValid,
  input  logic              fsmDecode,
  input  logic              fsmLoadFirst,
  input  logic              fsmLoadData,
  input  logic              fsmLoadAfterFull,
  input  logic              fifoFull,
  output logic [DATA_W-1:0] dataOut,
  output logic              parityDone,
  output logic              lowPktValid,
  output logic              parityErr
);

  rhpStrobe_t strb;

  rhp_ctrl u_ctrl (
    .clk              (clk),
    .rstN             (rstN),
    .pktValid         (pktValid),
    .fsmDecode        (fsmDecode),
    .fsmLoadFirst     (fsmLoadFirst),
    .fsmLoadData      (fsmLoadData),
    .fsmLoadAfterFull (fsmLoadAfterFull),
    .fifoFull         (fifoFull),
    .strb             (strb),
    .parityDone       (parityDone),
    .lowPktValid      (lowPktValid)
  );

  rhp_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .dataIn    (dataIn),
    .dataOut   (dataOut),
    .parityErr (parityErr)
  );

  p_err_after_done_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(parityErr) |-> $past(parityDone));

endmodule

// File: tb/rtr_hdr_parity_unit_tb.sv
module rtr_hdr_parity_unit_tb;

  logic       clk = 1'b0;
  logic       rstN;
  logic [7:0] dataIn;
  logic       pktValid, fsmDecode, fsmLoadFirst, fsmLoadData, fsmLoadAfterFull, fifoFull;
  logic [7:0] dataOut;
  logic       parityDone, lowPktValid, parityErr;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [7:0] prevOut;

  always #10 clk = ~clk;

  rtr_hdr_parity_unit u_dut (
    .clk(clk), .rstN(rstN), .dataIn(dataIn), .pktValid(pktValid),
    .fsmDecode(fsmDecode), .fsmLoadFirst(fsmLoadFirst), .fsmLoadData(fsmLoadData),
    .fsmLoadAfterFull(fsmLoadAfterFull), .fifoFull(fifoFull),
    .dataOut(dataOut), .parityDone(parityDone), .lowPktValid(lowPktValid),
    .parityErr(parityErr)
  );

  function automatic logic [7:0] xorAll(input logic [7:0] a, input logic [7:0] b);
    return a ^ b;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // drive at negedge, one rising edge, return at next negedge
  task automatic step(input logic dec, input logic lf, input logic ld, input logic laf,
                      input logic pv, input logic ff, input logic [7:0] d);
    fsmDecode = dec; fsmLoadFirst = lf; fsmLoadData = ld; fsmLoadAfterFull = laf;
    pktValid = pv; fifoFull = ff; dataIn = d;
    @(negedge clk);
  endtask

  task automatic sendPkt(input logic [7:0] hdr, input int len, input int stallPct,
                         input bit corrupt, input bit forceLastStall);
    logic [7:0] expPar;
    logic [7:0] pb;
    expPar = hdr;
    step(1, 0, 0, 0, 1, 0, hdr);
    chk("R7 done cleared on decode", parityDone, 0);
    chk("R8 err cleared at packet start", parityErr, 0);
    step(0, 1, 0, 0, 1, 0, 8'($urandom));
    chk("R2 header out", dataOut, hdr);
    prevOut = hdr;
    for (int i = 0; i < len; i++) begin
      logic [7:0] b;
      bit ff;
      bit last;
      b = 8'($urandom);
      last = (i == len - 1);
      ff = (int'($urandom % 100) < stallPct) || (forceLastStall && last);
      expPar = xorAll(expPar, b);
      step(0, 0, 1, 0, 1, ff, b);
      if (!ff) begin
        chk("R3 payload passed", dataOut, b);
        prevOut = b;
      end else begin
        chk("R4 output kept on stall", dataOut, prevOut);
        step(0, 0, 0, 0, 1, 1, 8'($urandom));
        chk("R4 output kept while full", dataOut, prevOut);
        step(0, 0, 0, 1, !last, 0, 8'($urandom));
        chk("R4 held byte replayed", dataOut, b);
        if (last) chk("R9 low valid pulse", lowPktValid, 1);
        else      chk("R10 no low valid pulse", lowPktValid, 0);
        prevOut = b;
      end
    end
    pb = corrupt ? (expPar ^ 8'(($urandom % 255) + 1)) : expPar;
    step(0, 0, 1, 0, 0, 0, pb);
    chk("R6 parity done", parityDone, 1);
    chk("R3 parity byte passed", dataOut, pb);
    chk("R9 pulse one cycle", lowPktValid, 0);
    step(0, 0, 0, 0, 0, 0, 8'h00);
    chk("R5 R8 error flag", parityErr, corrupt);
    step(0, 0, 0, 0, 0, 0, 8'h00);
    chk("R8 error held", parityErr, corrupt);
    chk("R7 done held", parityDone, 1);
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240517));
    rstN = 1'b0;
    step(0, 0, 0, 0, 0, 0, 8'h00);
    step(0, 0, 0, 0, 0, 0, 8'h00);
    chk("R1 dataOut reset", dataOut, 0);
    chk("R1 done reset", parityDone, 0);
    chk("R1 low valid reset", lowPktValid, 0);
    chk("R1 err reset", parityErr, 0);
    rstN = 1'b1;

    // directed: empty packet, last-byte stall, corrupt parity
    sendPkt(8'hA5, 0, 0, 0, 0);
    sendPkt(8'h3C, 3, 0, 0, 1);
    sendPkt(8'hFF, 4, 50, 1, 1);

    // mid-run reset with error flag set
    rstN = 1'b0;
    step(0, 0, 0, 0, 0, 0, 8'h00);
    chk("R1 err cleared by reset", parityErr, 0);
    chk("R1 done cleared by reset", parityDone, 0);
    chk("R1 dataOut cleared by reset", dataOut, 0);
    rstN = 1'b1;
    step(0, 1, 0, 0, 1, 0, 8'h77);
    chk("R1 header cleared by reset", dataOut, 0);

    // random packets
    for (int p = 0; p < 60; p++) begin
      sendPkt(8'($urandom), int'($urandom % 9), 30, bit'($urandom % 2), 0);
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule